// File: doc/BRIEF.md
# Two-Stage Fetch Front End with Instruction Squash

This block is the front end of a processor with two pipeline stages. The fetch stage presents a word address to instruction memory and receives the instruction word in the same cycle. The execute stage decodes, executes and writes back that instruction one cycle later. Between the stages the block keeps three registers: the fetch program counter, the instruction register that feeds execute, and the address of the instruction now in execute. Branch and link arithmetic in execute uses that address.

Execute tells the block when a control transfer takes effect, and supplies its destination. Every jump does this, including register-indirect jumps and jumps whose destination is the next word. A conditional branch does this only when it is taken. In that cycle the block discards the word being fetched by loading an all-zero word (a nop) into the instruction register, and it fetches next from the supplied destination. There are no delay slots. Data hazards do not arise, because all register and memory access happens in execute.

Top module: `fetch_front`

## Requirements
- R1: While reset is high at a rising clock edge (reset is synchronous and active high), the following edge leaves the fetch address, the execute-stage instruction and the execute-stage address all at zero. The first instruction executed after reset is therefore a nop.
- R2: When squash is low at a rising edge, the fetch address becomes the previous fetch address plus one.
- R3: When squash is low at a rising edge, the execute-stage instruction becomes the word that was on the instruction input during that cycle.
- R4: At every rising edge out of reset, the execute-stage address becomes the fetch address of the cycle just ended, whether or not squash is high.
- R5: When squash is high at a rising edge, the fetch address becomes the value on the redirect input.
- R6: When squash is high at a rising edge, the execute-stage instruction becomes 32'h00000000, whatever word was fetched.
- R7: While squash is low, the redirect input has no effect on the fetch address.
- R8: A squash whose destination equals the previous fetch address plus one still replaces the fetched word with a nop.
- R9: The fetch address is a word address ADDR_W bits wide. Stepping past the all-ones address wraps it to zero.
- R10: Squashes on consecutive cycles each take effect. Every one redirects fetch and inserts a nop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, never gated |
| rst | input | 1 | Synchronous active-high reset |
| imem_word_i | input | INSTR_W (32) | Instruction word at the current fetch address |
| squash_i | input | 1 | Execute reports a jump or a taken branch |
| redirect_i | input | ADDR_W (24) | Word address to fetch next when squash is high |
| fetch_addr_o | output | ADDR_W (24) | Word address sent to instruction memory |
| ex_instr_o | output | INSTR_W (32) | Instruction presented to execute |
| ex_pc_o | output | ADDR_W (24) | Word address of the instruction in execute |

## Verification
The corner that is hardest to reach from the ports is the squash whose destination is the very next sequential word. Here the fetch address looks the same as on a plain step, and only the nop in execute shows that the fetched word was dropped. The bench produces this case on purpose, and it also produces back-to-back squashes and a redirect to the all-ones address so that the next step wraps. Instruction memory is modelled as a function of the address, with every word non-zero. Each cycle the bench predicts all three outputs arithmetically from the fetch address it sampled and the squash it drove. In cycles without a squash it drives junk on the redirect input.

// File: rtl/fetch_front_pkg.sv
package fetch_front_pkg;
    parameter int unsigned DEF_ADDR_W  = 24;
    parameter int unsigned DEF_INSTR_W = 32;

    typedef enum logic {
        NEXT_SEQ      = 1'b0,
        NEXT_REDIRECT = 1'b1
    } next_src_e;
endpackage

// File: rtl/fe_next_addr.sv
module fe_next_addr
    import fetch_front_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              squash,
    input  logic [ADDR_W-1:0] redirect,
    output next_src_e         src,
    output logic [ADDR_W-1:0] next_pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    always_comb begin
        src = squash ? NEXT_REDIRECT : NEXT_SEQ;
        unique case (src)
            NEXT_REDIRECT: next_pc = redirect;
            default:       next_pc = cur_pc + STEP;
        endcase
    end
endmodule

// File: rtl/fe_squash_gate.sv
module fe_squash_gate #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_in,
    input  logic             squash,
    output logic [WIDTH-1:0] word_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign word_out[b] = word_in[b] & ~squash;
    end
endmodule

// File: rtl/fetch_front.sv
module fetch_front
    import fetch_front_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned INSTR_W = DEF_INSTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] imem_word_i,
    input  logic               squash_i,
    input  logic [ADDR_W-1:0]  redirect_i,
    output logic [ADDR_W-1:0]  fetch_addr_o,
    output logic [INSTR_W-1:0] ex_instr_o,
    output logic [ADDR_W-1:0]  ex_pc_o
);
    localparam logic [INSTR_W-1:0] NOP_WORD = '0;
    localparam logic [ADDR_W-1:0]  PC_RESET = '0;

    typedef struct packed {
        logic [ADDR_W-1:0]  pc;
        logic [INSTR_W-1:0] ir;
        logic [ADDR_W-1:0]  ex_pc;
    } stage_t;

    stage_t             st_d, st_q;
    next_src_e          next_src;
    logic [ADDR_W-1:0]  pc_next;
    logic [INSTR_W-1:0] gated_word;

    fe_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur_pc   (st_q.pc),
        .squash   (squash_i),
        .redirect (redirect_i),
        .src      (next_src),
        .next_pc  (pc_next)
    );

    fe_squash_gate #(.WIDTH(INSTR_W)) u_gate (
        .word_in  (imem_word_i),
        .squash   (next_src == NEXT_REDIRECT),
        .word_out (gated_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pc    = pc_next;
        st_d.ir    = gated_word;
        st_d.ex_pc = st_q.pc;
        if (rst) begin
            st_d.pc    = PC_RESET;
            st_d.ir    = NOP_WORD;
            st_d.ex_pc = PC_RESET;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fetch_addr_o = st_q.pc;
    assign ex_instr_o   = st_q.ir;
    assign ex_pc_o      = st_q.ex_pc;
endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk #(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned INSTR_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [INSTR_W-1:0] imem_word_i,
    input logic               squash_i,
    input logic [ADDR_W-1:0]  redirect_i,
    input logic [ADDR_W-1:0]  fetch_addr_o,
    input logic [INSTR_W-1:0] ex_instr_o,
    input logic [ADDR_W-1:0]  ex_pc_o
);
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_addr_o == '0 && ex_instr_o == '0 && ex_pc_o == '0));

    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        !squash_i |=> fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1'b1));

    a_r3_pass_word: assert property (@(posedge clk) disable iff (rst)
        !squash_i |=> ex_instr_o == $past(imem_word_i));

    a_r4_ex_pc_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ex_pc_o == $past(fetch_addr_o));

    a_r5_redirect: assert property (@(posedge clk) disable iff (rst)
        squash_i |=> fetch_addr_o == $past(redirect_i));

    a_r6_nop_insert: assert property (@(posedge clk) disable iff (rst)
        squash_i |=> ex_instr_o == '0);
endmodule

bind fetch_front fetch_front_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .imem_word_i  (imem_word_i),
    .squash_i     (squash_i),
    .redirect_i   (redirect_i),
    .fetch_addr_o (fetch_addr_o),
    .ex_instr_o   (ex_instr_o),
    .ex_pc_o      (ex_pc_o)
);

// File: tb/tb_fetch_front.sv
module tb_fetch_front;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          squash = 1'b0;
    logic [AW-1:0] redirect = '0;
    logic [IW-1:0] imem_word;
    logic [AW-1:0] fetch_addr;
    logic [IW-1:0] ex_instr;
    logic [AW-1:0] ex_pc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [AW-1:0] exp_pc = '0;
    logic [IW-1:0] exp_ir = '0;
    logic [AW-1:0] exp_ex = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Never-zero instruction memory, so a nop can only come from a squash.
    function automatic logic [IW-1:0] mem_word(input logic [AW-1:0] a);
        return {8'hC3 ^ a[7:0], a} | 32'h8000_0000;
    endfunction

    assign imem_word = mem_word(fetch_addr);

    fetch_front dut (
        .clk          (clk),
        .rst          (rst),
        .imem_word_i  (imem_word),
        .squash_i     (squash),
        .redirect_i   (redirect),
        .fetch_addr_o (fetch_addr),
        .ex_instr_o   (ex_instr),
        .ex_pc_o      (ex_pc)
    );

    task automatic check(input string req, input logic [IW-1:0] act, input logic [IW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, predict, check at the next negedge.
    task automatic step(input logic k, input logic [AW-1:0] tgt, input string tag);
        logic [AW-1:0] pre;
        pre = fetch_addr;
        squash = k;
        redirect = tgt;
        @(posedge clk);
        @(negedge clk);
        exp_ex = pre;
        exp_ir = k ? '0 : mem_word(pre);
        exp_pc = k ? tgt : AW'(pre + 1'b1);
        if (k) begin
            check({tag, " R5 redirect"}, IW'(fetch_addr), IW'(exp_pc));
            check({tag, " R6 nop"}, ex_instr, exp_ir);
        end else begin
            check({tag, " R2 R7 step"}, IW'(fetch_addr), IW'(exp_pc));
            check({tag, " R3 pass"}, ex_instr, exp_ir);
        end
        check({tag, " R4 ex_pc"}, IW'(ex_pc), IW'(exp_ex));
    endtask

    task automatic check_reset(input string tag);
        check({tag, " R1 fetch"}, IW'(fetch_addr), '0);
        check({tag, " R1 instr"}, ex_instr, '0);
        check({tag, " R1 ex_pc"}, IW'(ex_pc), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset("after reset");

        // Sequential sweep with periodic squashes; junk redirect when idle (R7).
        for (int i = 0; i < 400; i++) begin
            if (i % 7 == 3)
                step(1'b1, AW'(i * 37 + 5), "sweep");
            else
                step(1'b0, AW'(32'hDEAD00 ^ (i * 131)), "sweep R7");
        end

        // R8: squash to the very next word still kills.
        for (int i = 0; i < 5; i++) begin
            step(1'b1, AW'(fetch_addr + 1'b1), "R8 next-word");
            step(1'b0, '1, "R8 after");
        end

        // R10: back-to-back squashes.
        for (int i = 0; i < 6; i++)
            step(1'b1, AW'(24'h100 + i * 3), "R10 burst");
        step(1'b0, '0, "R10 resume");

        // R9: wrap at the all-ones address.
        step(1'b1, '1, "R9 setup");
        step(1'b0, 24'h123456, "R9 wrap");
        check("R9 wrapped to zero", IW'(fetch_addr), '0);
        step(1'b0, '0, "R9 post");

        // R1: synchronous reset in mid-run.
        squash = 1'b1;
        redirect = 24'h777777;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        squash = 1'b0;
        check_reset("mid-run reset");
        step(1'b0, '0, "R1 restart");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule